// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block evaluates integer arithmetic expressions written in postfix (reverse Polish) order. Tokens arrive one per cycle over a valid/ready stream. Each token is an operand (a signed 16-bit value), an operator (add, subtract, multiply or divide) or an end marker. Operands are pushed onto an internal register stack. An operator removes the two top entries, combines them, and pushes the single result back. Tokens are taken strictly in the order they arrive.

When the end marker is accepted, the only remaining stack entry is presented as the result for one cycle, together with a done pulse. During that cycle the block holds its ready output low. The stack is then empty again for the next expression. The following faults are reported through an error flag that accompanies the done pulse: a push to a full stack, an operator with fewer than two entries below it, division by zero, and a final depth other than one. After a fault, every token up to the end marker is discarded.

Top module: `rpn_eval`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_done` and `out_error` are 0, and the stack is empty. A token is accepted on a rising edge where `in_valid` and `in_ready` are both 1. An operand token (`in_kind` = 0) pushes `in_data` onto the top of the stack.
- R2: An operator token (`in_kind` = 1) pops two entries and pushes one result. The deeper entry is the left operand. With `in_op` = 0 the result is left plus top, and with `in_op` = 1 it is left minus top, both wrapped to 16 bits.
- R3: With `in_op` = 2 the result is the low 16 bits of the product of the two signed entries.
- R4: With `in_op` = 3 the result is the signed quotient of left divided by top, truncated toward zero.
- R5: An end token (`in_kind` = 2 or 3) that is accepted raises `out_done` for exactly one cycle, starting one clock after acceptance. In that cycle `out_result` holds the remaining entry and `in_ready` is 0.
- R6: The stack holds 8 entries. Eight operands are accepted without error, and a ninth operand before any reducing operator causes an error.
- R7: An operator accepted while fewer than two entries are on the stack causes an error.
- R8: If the stack depth at the end token is not exactly one (including zero), `out_error` is 1 together with `out_done` and `out_result` is 0. `out_error` is never 1 without `out_done`.
- R9: A divide whose top entry is zero causes an error.
- R10: After an error, tokens are discarded until the end token. The expression that follows starts from an empty stack and evaluates normally.
- R11: A token held valid while `in_ready` is 0 is not taken. It is accepted exactly once, on the first edge where `in_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Token present on the input fields |
| in_ready | output | 1 | Block can take a token this cycle |
| in_kind | input | 2 | 0 operand, 1 operator, 2 or 3 end of expression |
| in_op | input | 2 | Operator code: 0 add, 1 subtract, 2 multiply, 3 divide |
| in_data | input | 16 | Signed operand value |
| out_done | output | 1 | One-cycle pulse presenting a finished expression |
| out_result | output | 16 | Signed result, valid while out_done is 1 |
| out_error | output | 1 | Expression faulted, valid while out_done is 1 |

## Verification
Operand and operator tokens change only internal stack state at the edge that accepts them. Their effect becomes visible only through the final result. The result, done and error outputs are due exactly one clock after the edge that accepts the end token, and in that same cycle ready is low. Every token is driven on a falling edge, and every check samples at the falling edge that follows the accepting edge, so the bench reads the presented cycle and never an edge. A separate directed sequence keeps a token valid across the low-ready cycle to confirm that it is taken exactly once, one cycle later.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        TK_NUM = 2'd0,
        TK_OPR = 2'd1,
        TK_END = 2'd2,
        TK_ENDALT = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } opcode_e;

    typedef struct packed {
        logic signed [WORD_W-1:0] value;
        logic                     fault;
    } alu_res_t;

    // lhs is the deeper stack entry, rhs the top one
    function automatic alu_res_t rpn_apply(
        input opcode_e                  op,
        input logic signed [WORD_W-1:0] lhs,
        input logic signed [WORD_W-1:0] rhs
    );
        alu_res_t r;
        r.value = '0;
        r.fault = 1'b0;
        unique case (op)
            OP_ADD: r.value = lhs + rhs;
            OP_SUB: r.value = lhs - rhs;
            OP_MUL: r.value = lhs * rhs;
            OP_DIV: begin
                if (rhs == '0) r.fault = 1'b1;
                else           r.value = lhs / rhs;
            end
            default: r.value = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rpn_alu.sv
module rpn_alu
    import rpn_pkg::*;
(
    input  opcode_e                  op,
    input  logic signed [WORD_W-1:0] lhs,
    input  logic signed [WORD_W-1:0] rhs,
    output alu_res_t                 res
);

    always_comb begin
        res = rpn_apply(op, lhs, rhs);
    end

endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push_en,
    input  logic [W-1:0]     push_val,
    input  logic             fold_en,
    input  logic [W-1:0]     fold_val,
    output logic [W-1:0]     top_val,
    output logic [W-1:0]     sub_val,
    output logic [LVL_W-1:0] level
);

    logic [W-1:0] slot [DEPTH];

    // level counts entries; the top entry sits at slot[level-1]
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            level <= '0;
        end else if (push_en) begin
            level <= level + LVL_W'(1);
        end else if (fold_en) begin
            level <= level - LVL_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push_en && level == LVL_W'(g)) begin
                    slot[g] <= push_val;
                end else if (fold_en && level == LVL_W'(g + 2)) begin
                    slot[g] <= fold_val;
                end
            end
        end
    endgenerate

    always_comb begin
        top_val = '0;
        sub_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == LVL_W'(i + 1)) top_val = slot[i];
            if (level == LVL_W'(i + 2)) sub_val = slot[i];
        end
    end

    // R6: the depth never exceeds the capacity
    a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R1: a push adds exactly one entry
    a_r1_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push_en && !clear) |=> level == $past(level) + LVL_W'(1));

    // R2: a fold removes exactly one entry
    a_r2_fold_shrinks: assert property (@(posedge clk) disable iff (rst)
        (fold_en && !push_en && !clear) |=> level == $past(level) - LVL_W'(1));

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
    import rpn_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_kind,
    input  logic [1:0]               in_op,
    input  logic signed [WORD_W-1:0] in_data,
    output logic                     out_done,
    output logic signed [WORD_W-1:0] out_result,
    output logic                     out_error
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    tok_kind_e  kind;
    opcode_e    opc;
    logic       accept;
    logic       is_num, is_opr, is_end;
    logic       fault_q;
    logic       full, short;
    logic       push_en, fold_en, clear, set_fault;
    logic [WORD_W-1:0] top_val, sub_val;
    logic [LVL_W-1:0]  level;
    alu_res_t   alu_out;

    assign kind   = tok_kind_e'(in_kind);
    assign opc    = opcode_e'(in_op);
    assign in_ready = !out_done;
    assign accept = in_valid && in_ready;

    assign is_num = (kind == TK_NUM);
    assign is_opr = (kind == TK_OPR);
    assign is_end = (kind == TK_END) || (kind == TK_ENDALT);

    assign full  = (level == LVL_W'(DEPTH));
    assign short = (level < LVL_W'(2));

    rpn_alu u_alu (
        .op  (opc),
        .lhs (sub_val),
        .rhs (top_val),
        .res (alu_out)
    );

    always_comb begin
        push_en   = accept && is_num && !fault_q && !full;
        fold_en   = accept && is_opr && !fault_q && !short && !alu_out.fault;
        clear     = accept && is_end;
        set_fault = accept && !fault_q &&
                    ((is_num && full) || (is_opr && (short || alu_out.fault)));
    end

    rpn_stack #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .push_en  (push_en),
        .push_val (in_data),
        .fold_en  (fold_en),
        .fold_val (alu_out.value),
        .top_val  (top_val),
        .sub_val  (sub_val),
        .level    (level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q    <= 1'b0;
            out_done   <= 1'b0;
            out_error  <= 1'b0;
            out_result <= '0;
        end else begin
            out_done <= clear;
            if (clear) begin
                fault_q <= 1'b0;
                if (fault_q || level != LVL_W'(1)) begin
                    out_error  <= 1'b1;
                    out_result <= '0;
                end else begin
                    out_error  <= 1'b0;
                    out_result <= top_val;
                end
            end else begin
                out_error <= 1'b0;
                if (set_fault) fault_q <= 1'b1;
            end
        end
    end

    // R5: an accepted end token is presented on the next cycle
    a_r5_done_follows_end: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && is_end) |=> out_done);

    // R5: done lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R8: error only accompanies done
    a_r8_error_with_done: assert property (@(posedge clk) disable iff (rst)
        out_error |-> out_done);

    // R10: the stack is empty while a result is presented
    a_r10_empty_after_end: assert property (@(posedge clk) disable iff (rst)
        out_done |-> level == '0);

    // R10: a faulted expression leaves the depth untouched until its end
    a_r10_discard: assert property (@(posedge clk) disable iff (rst)
        (fault_q && in_valid && in_ready && !is_end) |=> $stable(level));

    // R9: a divide by a zero top entry does not reduce the stack
    a_r9_div_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && is_opr && opc == OP_DIV && top_val == '0 &&
         !fault_q && !short) |=> $stable(level));

endmodule

// File: tb/rpn_eval_bench.sv
`timescale 1ns/1ps
module rpn_eval_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_kind;
    logic [1:0]  in_op;
    logic signed [15:0] in_data;
    logic        out_done;
    logic signed [15:0] out_result;
    logic        out_error;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rpn_eval u_rpn_eval (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_kind    (in_kind),
        .in_op      (in_op),
        .in_data    (in_data),
        .out_done   (out_done),
        .out_result (out_result),
        .out_error  (out_error)
    );

    function automatic logic [19:0] tn(input int v);
        return {2'd0, 2'd0, 16'(v)};
    endfunction
    function automatic logic [19:0] to(input int c);
        return {2'd1, 2'(c), 16'd0};
    endfunction
    function automatic logic [19:0] te();
        return {2'd2, 2'd0, 16'd0};
    endfunction

    localparam int NT = 81;
    localparam int NE = 15;

    localparam logic [19:0] TOKS [NT] = '{
        tn(3), tn(4), to(2), tn(5), tn(6), to(2), to(0), te(),
        tn(4), tn(5), to(0), tn(7), tn(2), to(1), to(2), te(),
        tn(2), tn(9), to(1), te(),
        tn(100), tn(7), to(3), te(),
        tn(-7), tn(2), to(3), te(),
        tn(300), tn(300), to(2), te(),
        tn(200), tn(200), to(2), te(),
        tn(3), tn(4), to(2), te(),
        tn(5), tn(0), to(3), te(),
        tn(7), to(0), te(),
        tn(1), tn(2), te(),
        te(),
        tn(1), tn(1), tn(1), tn(1), tn(1), tn(1), tn(1), tn(1), tn(1), te(),
        tn(1), tn(2), tn(3), tn(4), tn(5), tn(6), tn(7), tn(8),
        to(0), to(0), to(0), to(0), to(0), to(0), to(0), te(),
        tn(6), tn(7), to(2), te()
    };

    localparam int EXP_VAL [NE] = '{
        42, 45, -7, 14, -3, 24464, -25536, 12,
        0, 0, 0, 0, 0, 36, 42
    };
    localparam bit EXP_ERR [NE] = '{
        0, 0, 0, 0, 0, 0, 0, 0,
        1, 1, 1, 1, 1, 0, 0
    };
    localparam string ETAG [NE] = '{
        "R3", "R2", "R2", "R4", "R4", "R3", "R3", "R1",
        "R9", "R7", "R8", "R8", "R6", "R6", "R10"
    };

    task automatic check(input bit ok, input string tag,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // caller is at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [19:0] t);
        while (!in_ready) @(negedge clk);
        in_kind  = t[19:18];
        in_op    = t[17:16];
        in_data  = t[15:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1600000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ei;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_kind  = '0;
        in_op    = '0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // r1_ reset state
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(out_done == 1'b0, "R1 done after reset", out_done, 0);
        check(out_error == 1'b0, "R1 error after reset", out_error, 0);

        ei = 0;
        for (int i = 0; i < NT; i++) begin
            send(TOKS[i]);
            if (TOKS[i][19:18] == 2'd2) begin
                check(out_done == 1'b1, {ETAG[ei], " R5 done"}, out_done, 1);
                check(in_ready == 1'b0, {ETAG[ei], " R5 ready low"}, in_ready, 0);
                check(out_error == EXP_ERR[ei], {ETAG[ei], " error"},
                      out_error, EXP_ERR[ei]);
                check(int'(out_result) == EXP_VAL[ei], {ETAG[ei], " result"},
                      int'(out_result), EXP_VAL[ei]);
                ei++;
            end
        end

        // R5 and R11: token held across the low-ready cycle is taken once
        send(tn(5));
        send(te());
        check(out_done == 1'b1 && int'(out_result) == 5, "R5 plain result",
              int'(out_result), 5);
        in_kind  = 2'd0;
        in_op    = 2'd0;
        in_data  = 16'sd99;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_done == 1'b0, "R5 done one cycle only", out_done, 0);
        check(in_ready == 1'b1, "R11 ready back", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        send(te());
        check(out_error == 1'b0, "R11 held token taken once (error)", out_error, 0);
        check(int'(out_result) == 99, "R11 held token value", int'(out_result), 99);

        // R10: error mid-expression, rest discarded, next expression clean
        send(to(0));
        send(tn(8));
        send(tn(9));
        send(te());
        check(out_error == 1'b1, "R10 discarded tail still errors", out_error, 1);
        send(tn(20));
        send(tn(3));
        send(to(1));
        send(te());
        check(out_error == 1'b0 && int'(out_result) == 17, "R10 clean after fault",
              int'(out_result), 17);

        // R1: reset in the middle of an expression empties the stack
        send(tn(1));
        send(tn(2));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send(tn(4));
        send(te());
        check(out_error == 1'b0 && int'(out_result) == 4, "R1 reset empties stack",
              int'(out_result), 4);

        // R8: out_error stays low outside done
        @(negedge clk);
        check(out_error == 1'b0 && out_done == 1'b0, "R8 error idle", out_error, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule